// File: doc/BRIEF.md
# Auto-Reload Timer Baud Rate Generator

This block produces the bit-rate tick that an asynchronous serial port uses for its bit timing. The system clock is taken as the oscillator clock. A prescaler divides it by twelve to give a machine-cycle enable, and a timer counts once on each such enable. In its usual mode the timer is eight bits wide. It overflows when it steps past all ones and, on that same edge, takes its start value again from a reload register. No count is lost at the overflow. A post-divider then counts the overflows and emits one baud tick for every 32 of them. When the double-rate bit is set, it emits one tick for every 16.

A second mode joins the two reload bytes into a 16-bit counter that runs freely and wraps to zero. Software must reload it after each overflow, and it does so with a one-cycle load strobe. This mode reaches very low bit rates. The block has no interrupt logic and no serial framing logic. A rising run enable loads the counter and starts the prescaler and post-divider from zero. With the run enable low, neither pulse output is produced.

In eight-bit mode, one tick spans 12 × (256 − reload_hi) × 32 clocks when dbl_rate is low, and 12 × (256 − reload_hi) × 16 clocks when it is high. For example, a reload of FFh with double rate gives one tick per 192 clocks, which is 62.5k ticks per second at a 12 MHz clock. A reload of FDh without double rate gives one tick per 1152 clocks, which is about 9600 per second at 11.059 MHz.

Top module: `baud_tmr_gen`

## Requirements
- R1: While running, the timer advances exactly once every 12 clock cycles. In eight-bit mode, successive overflow pulses are 12 × (256 − reload_hi) cycles apart.
- R2: In eight-bit mode (mode16 = 0), the overflow of the low byte from FFh reloads it with reload_hi on the same edge. The next overflow therefore follows after exactly 256 − reload_hi machine cycles.
- R3: With dbl_rate = 0, baud_tick pulses once per 32 overflows. In eight-bit mode this is a period of 384 × (256 − reload_hi) cycles.
- R4: With dbl_rate = 1, baud_tick pulses once per 16 overflows.
- R5: ovf_pulse and baud_tick are each one clock cycle wide. baud_tick is high only in a cycle in which ovf_pulse is also high.
- R6: A rising run_en loads the counter and clears the prescaler and post-divider. In eight-bit mode, the first overflow appears 12 × (256 − reload_hi) − 1 cycles after the loading edge, and the first tick appears 12 × (256 − reload_hi) × N − 1 cycles after it, where N is 32 or 16. While run_en is low, neither output pulses.
- R7: In 16-bit mode (mode16 = 1), the counter starts from {reload_hi, reload_lo} and overflows when it steps past FFFFh. It then wraps to 0000h and takes no automatic reload.
- R8: In 16-bit mode, a sw_load strobe loads {reload_hi, reload_lo}. The strobe takes priority over counting on the same edge, including the edge of an overflow, and ovf_pulse is still produced for that overflow.
- R9: While rst_n is low, ovf_pulse and baud_tick are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; its rising edge loads the counter |
| mode16 | input | 1 | 0: eight-bit auto-reload, 1: 16-bit free-running |
| dbl_rate | input | 1 | 0: post-divide by 32, 1: by 16 |
| reload_hi | input | 8 | Reload value (eight-bit mode) or high start byte (16-bit mode) |
| reload_lo | input | 8 | Low start byte used in 16-bit mode |
| sw_load | input | 1 | One-cycle strobe that reloads the counter |
| ovf_pulse | output | 1 | One-cycle pulse on each timer overflow |
| baud_tick | output | 1 | One-cycle baud-rate tick |

## Verification
Two functions can occur in the same cycle. In 16-bit mode, an overflow and a software reload can land on the same edge. Separately, the post-divider's tick always falls in an overflow cycle. The bench raises sw_load in the very cycle in which ovf_pulse is seen, so the strobe is sampled on the overflow edge. It then checks three things: the next overflow arrives exactly 16 machine cycles later and not after a wrap through zero, the overflow pulse of that cycle was not suppressed, and the tick arrives together with the sixteenth overflow.

// File: rtl/baud_tmr_pkg.sv
package baud_tmr_pkg;

  typedef enum logic {
    TMR_RELOAD8 = 1'b0,
    TMR_FREE16  = 1'b1
  } tmr_mode_e;

  // Value the counter takes on a load: a start event or a software strobe.
  function automatic logic [15:0] load_value(tmr_mode_e mode, logic [7:0] hi, logic [7:0] lo);
    return (mode == TMR_FREE16) ? {hi, lo} : {8'h00, hi};
  endfunction

  // True when the next machine-cycle step overflows the timer.
  function automatic logic at_top(tmr_mode_e mode, logic [15:0] cnt);
    return (mode == TMR_FREE16) ? (&cnt) : (&cnt[7:0]);
  endfunction

  // Value after one machine-cycle step.
  function automatic logic [15:0] step_value(tmr_mode_e mode, logic [15:0] cnt, logic [7:0] hi);
    logic [15:0] nxt;
    if (mode == TMR_FREE16) nxt = cnt + 16'd1;
    else if (&cnt[7:0])     nxt = {8'h00, hi};
    else                    nxt = {8'h00, cnt[7:0] + 8'd1};
    return nxt;
  endfunction

  // True when the overflow counter sits on the last position of its cycle.
  function automatic logic post_last(logic [4:0] pd, logic dbl);
    return dbl ? (&pd[3:0]) : (&pd);
  endfunction

endpackage

// File: rtl/baud_mc_prescaler.sv
module baud_mc_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mc_tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign mc_tick = run && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (!run || mc_tick)  pcnt <= '0;
    else                       pcnt <= pcnt + PW'(1);
  end
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
  import baud_tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mc_tick,
  input  logic        mode16,
  input  logic        sw_load,
  input  logic [7:0]  reload_hi,
  input  logic [7:0]  reload_lo,
  output logic        ovf,
  output logic [15:0] cnt_q
);
  tmr_mode_e mode;
  assign mode = tmr_mode_e'(mode16);
  assign ovf  = mc_tick && at_top(mode, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start || sw_load) cnt_q <= load_value(mode, reload_hi, reload_lo);
    else if (mc_tick)          cnt_q <= step_value(mode, cnt_q, reload_hi);
  end
endmodule

// File: rtl/baud_post_div.sv
module baud_post_div
  import baud_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ovf,
  input  logic dbl,
  output logic tick,
  output logic [4:0] pd_q
);
  assign tick = ovf && post_last(pd_q, dbl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pd_q <= '0;
    else if (!run) pd_q <= '0;
    else if (ovf)  pd_q <= pd_q + 5'd1;
  end
endmodule

// File: rtl/baud_tmr_gen.sv
module baud_tmr_gen #(
  parameter int PRESCALE = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       mode16,
  input  logic       dbl_rate,
  input  logic [7:0] reload_hi,
  input  logic [7:0] reload_lo,
  input  logic       sw_load,
  output logic       ovf_pulse,
  output logic       baud_tick
);
  logic        run_q;
  logic        start;
  logic        mc_tick;
  logic [15:0] cnt_q;
  logic [4:0]  pd_q;

  assign start = run_en && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  baud_mc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .mc_tick(mc_tick)
  );

  baud_reload_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .mc_tick(mc_tick),
    .mode16(mode16), .sw_load(sw_load), .reload_hi(reload_hi),
    .reload_lo(reload_lo), .ovf(ovf_pulse), .cnt_q(cnt_q)
  );

  baud_post_div u_post (
    .clk(clk), .rst_n(rst_n), .run(run_q), .ovf(ovf_pulse),
    .dbl(dbl_rate), .tick(baud_tick), .pd_q(pd_q)
  );
endmodule

// File: rtl/baud_tmr_gen_chk.sv
module baud_tmr_gen_chk #(
  parameter int PRESCALE = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        run_q,
  input logic        mode16,
  input logic        sw_load,
  input logic [7:0]  reload_hi,
  input logic [7:0]  reload_lo,
  input logic        mc_tick,
  input logic [15:0] cnt_q,
  input logic        ovf_pulse,
  input logic        baud_tick
);
  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (!run_q) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (mc_tick) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1;
    end
  end

  AST_MC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && seen) |-> (gap == PRESCALE - 1)); // R1
  AST_RELOAD8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !mode16 && !sw_load) |=> (cnt_q[7:0] == $past(reload_hi))); // R2
  AST_TICK_IN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ovf_pulse); // R5
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!ovf_pulse && !baud_tick)); // R6
  AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && mode16 && !sw_load) |=> (cnt_q == 16'h0000)); // R7
  AST_SWLOAD16: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_load && mode16) |=> (cnt_q == {$past(reload_hi), $past(reload_lo)})); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!ovf_pulse && !baud_tick)); // R9
endmodule

bind baud_tmr_gen baud_tmr_gen_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_q(run_q), .mode16(mode16),
  .sw_load(sw_load), .reload_hi(reload_hi), .reload_lo(reload_lo),
  .mc_tick(mc_tick), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse), .baud_tick(baud_tick)
);

// File: tb/tb_baud_tmr_gen.sv
module tb_baud_tmr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, mode16 = 1'b0, dbl_rate = 1'b0, sw_load = 1'b0;
  logic [7:0] reload_hi = 8'h00, reload_lo = 8'h00;
  logic ovf_pulse, baud_tick;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  localparam int WD_LIMIT = 190000;

  always #2 clk = ~clk;

  baud_tmr_gen dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode16(mode16),
    .dbl_rate(dbl_rate), .reload_hi(reload_hi), .reload_lo(reload_lo),
    .sw_load(sw_load), .ovf_pulse(ovf_pulse), .baud_tick(baud_tick)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  // reload, double-rate flag, expected tick period in clocks
  localparam int NV = 6;
  localparam logic [7:0] V_RLD [NV] = '{8'hFF, 8'hFD, 8'hFD, 8'hF4, 8'hE8, 8'hF0};
  localparam logic       V_DBL [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int         V_PER [NV] = '{192, 1152, 576, 2304, 9216, 6144};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input logic m16, input logic dbl, input logic [7:0] hi,
                           input logic [7:0] lo, output int s);
    @(negedge clk);
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    mode16 = m16; dbl_rate = dbl; reload_hi = hi; reload_lo = lo;
    run_en = 1'b1;
    @(posedge clk);
    #1 s = cyc;
  endtask

  task automatic wait_evt(input bit want_tick, input int limit, output int at, output bit found);
    found = 1'b0;
    at = -1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (want_tick ? baud_tick : ovf_pulse) begin
        at = cyc;
        found = 1'b1;
        return;
      end
    end
  endtask

  initial begin
    int s, a0, a1, t0, t1, prev, ovp, quiet;
    bit f;
    // reset state
    repeat (3) @(negedge clk);
    check(ovf_pulse == 1'b0, "R9 ovf_pulse in reset", ovf_pulse, 0);
    check(baud_tick == 1'b0, "R9 baud_tick in reset", baud_tick, 0);
    rst_n = 1'b1;

    // eight-bit auto-reload vectors
    for (int v = 0; v < NV; v++) begin
      ovp = 12 * (256 - int'(V_RLD[v]));
      start_run(1'b0, V_DBL[v], V_RLD[v], 8'h5A, s);
      wait_evt(1'b0, ovp + 20, a0, f);
      check(f && (a0 - s == ovp - 1), "R6 first overflow offset", a0 - s, ovp - 1);
      wait_evt(1'b0, ovp + 20, a1, f);
      check(f && (a1 - a0 == ovp), "R1 R2 overflow spacing", a1 - a0, ovp);
      wait_evt(1'b1, V_PER[v] + 20, t0, f);
      check(f && (t0 - s == V_PER[v] - 1),
            V_DBL[v] ? "R4 R6 first tick offset" : "R3 R6 first tick offset",
            t0 - s, V_PER[v] - 1);
      check(ovf_pulse == 1'b1, "R5 tick inside overflow cycle", ovf_pulse, 1);
      @(negedge clk);
      check(baud_tick == 1'b0 && ovf_pulse == 1'b0, "R5 one-cycle pulses",
            baud_tick + ovf_pulse, 0);
      wait_evt(1'b1, V_PER[v] + 20, t1, f);
      check(f && (t1 - t0 == V_PER[v]),
            V_DBL[v] ? "R4 tick period /16" : "R3 tick period /32", t1 - t0, V_PER[v]);
    end

    // run enable low: no pulses
    @(negedge clk);
    run_en = 1'b0;
    quiet = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      quiet = quiet + ovf_pulse + baud_tick;
    end
    check(quiet == 0, "R6 no pulses while stopped", quiet, 0);

    // 16-bit mode with software reload on the overflow edge
    start_run(1'b1, 1'b1, 8'hFF, 8'hF0, s);
    prev = s;
    for (int k = 1; k <= 16; k++) begin
      wait_evt(1'b0, 400, a0, f);
      if (k == 1) check(f && (a0 - s == 191), "R7 16-bit first overflow", a0 - s, 191);
      else        check(f && (a0 - prev == 192), "R8 reload on overflow edge", a0 - prev, 192);
      check(baud_tick == (k == 16), "R4 R8 tick at sixteenth overflow", baud_tick, (k == 16));
      prev = a0;
      sw_load = 1'b1;
      @(negedge clk);
      sw_load = 1'b0;
    end

    // 16-bit mode without software reload: wraps to zero, no early overflow
    start_run(1'b1, 1'b0, 8'hFF, 8'hF0, s);
    wait_evt(1'b0, 400, a0, f);
    check(f && (a0 - s == 191), "R7 16-bit start value", a0 - s, 191);
    quiet = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      quiet = quiet + ovf_pulse;
    end
    check(quiet == 0, "R7 no auto reload after wrap", quiet, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule